// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This block sits between an execution unit and memory. Each access arrives as a displacement relative to the start of a region, and the block turns it into a physical address by adding that region's base register. The same displacement is checked against the region's limit register. If the displacement falls outside the region, or if adding the base would run past the top of the physical address space, the access is stopped. It is not sent to memory, and a fault pulse is raised instead.

The block holds two base/limit pairs. One describes the running job's private region and the other a region that several jobs share. A one-bit region select on each access picks the pair. To move a job to a new place in memory, software only reloads its base register. The displacements the program issues stay the same. Register writes go through a single load port, and each write names a region and a field.

Top module: `reloc_guard`

## Requirements
- R1: After reset, mem_req and fault are low and every base and limit register holds zero, so the first access made before any load faults with fault_code bit 0 set.
- R2: An accepted access presented in cycle t drives mem_req high, mem_write equal to acc_write, and mem_addr equal to base plus acc_disp, all in cycle t+1. The registered outputs change on the clock edge that ends cycle t.
- R3: acc_region 0 selects the private pair and acc_region 1 selects the shared pair. The chosen pair alone sets the address and the limit check.
- R4: After only the base register of a region is reloaded, the same displacement maps to the new base plus that displacement, and the limit check is unchanged.
- R5: A displacement greater than or equal to the region limit is a range fault and sets fault_code bit 0. A displacement of limit minus 1 is accepted.
- R6: If base plus displacement carries out of ADDR_W bits, the access is a wrap fault and sets fault_code bit 1. A sum that equals the all-ones address is accepted.
- R7: A faulting access raises fault for exactly the one cycle t+1 and keeps mem_req low in that cycle. Without an access, neither mem_req nor fault is raised. Both fault bits may be set together.
- R8: A load (ld_en, with ld_region, ld_field where 0 selects base and 1 selects limit, and ld_value) takes effect from the next cycle on. An access in the same cycle as the load uses the old value.
- R9: A load to one region leaves the other region's registers unchanged.
- R10: While mem_req is low, mem_addr is zero and mem_write is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_region | input | 1 | 0 private pair, 1 shared pair |
| acc_disp | input | DISP_W | Displacement within the region |
| ld_en | input | 1 | Register load strobe |
| ld_region | input | 1 | Region whose register is loaded |
| ld_field | input | 1 | 0 base, 1 limit |
| ld_value | input | ADDR_W | Value to load |
| mem_req | output | 1 | Forwarded memory request |
| mem_write | output | 1 | Forwarded write strobe |
| mem_addr | output | ADDR_W | Physical address |
| fault | output | 1 | Protection fault pulse |
| fault_code | output | 2 | Bit 0 range fault, bit 1 wrap fault |

## Verification
The bound checker watches every cycle for the following. A forwarded request must match the base selected in the previous cycle plus that cycle's displacement. The displacement behind it must have been under the selected limit, and the address must not have wrapped. Requests and faults must be mutually exclusive and must always follow an access. An idle output must read as zero. Some behaviour only the directed scenarios can show: relocation by reloading a base, the exact limit and all-ones boundaries, and the old-value rule for a load in the same cycle as an access. The scenarios also cover the isolation between the private and shared pairs, and the values the registers hold after reset.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  // Region selector encoding
  typedef enum logic {
    RGN_PRIVATE = 1'b0,
    RGN_SHARED  = 1'b1
  } region_e;

  // Register field selector for the load port
  typedef enum logic {
    FLD_BASE  = 1'b0,
    FLD_LIMIT = 1'b1
  } field_e;

  // Fault code bit positions
  localparam int unsigned FC_RANGE = 0;
  localparam int unsigned FC_WRAP  = 1;
  localparam int unsigned FC_W     = 2;
  localparam int unsigned NREGIONS = 2;
endpackage

// File: rtl/reloc_bank.sv
module reloc_bank
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NSETS  = NREGIONS,
  localparam int unsigned SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_set,
  input  logic              wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_set,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit
);
  logic [NSETS-1:0][ADDR_W-1:0] base_all;
  logic [NSETS-1:0][ADDR_W-1:0] limit_all;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic [ADDR_W-1:0] base_r;
    logic [ADDR_W-1:0] limit_r;
    logic              hit;

    assign hit = wr_en && (wr_set == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_r  <= '0;
        limit_r <= '0;
      end else if (hit) begin
        if (wr_field == FLD_BASE) base_r  <= wr_data;
        else                      limit_r <= wr_data;
      end
    end

    assign base_all[g]  = base_r;
    assign limit_all[g] = limit_r;
  end

  // Read side sees the registered values, so a load in this cycle is not visible yet
  assign rd_base  = base_all[rd_set];
  assign rd_limit = limit_all[rd_set];
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int unsigned DISP_W = 12,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned PAD_W = ADDR_W - DISP_W
) (
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] phys,
  output logic              range_err,
  output logic              wrap_err
);
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W:0]   sum;

  if (PAD_W > 0) begin : g_pad
    assign disp_ext = {{PAD_W{1'b0}}, disp};
  end else begin : g_nopad
    assign disp_ext = disp_ext_full(disp);
  end

  function automatic logic [ADDR_W-1:0] disp_ext_full(input logic [DISP_W-1:0] d);
    return ADDR_W'(d);
  endfunction

  always_comb begin
    sum       = {1'b0, base} + {1'b0, disp_ext};
    phys      = sum[ADDR_W-1:0];
    wrap_err  = sum[ADDR_W];
    range_err = (disp_ext >= limit);
  end
endmodule

// File: rtl/reloc_outreg.sv
module reloc_outreg
  import reloc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] phys,
  input  logic              range_err,
  input  logic              wrap_err,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fault,
  output logic [FC_W-1:0]   fault_code
);
  logic any_err;
  assign any_err = range_err || wrap_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req    <= 1'b0;
      mem_write  <= 1'b0;
      mem_addr   <= '0;
      fault      <= 1'b0;
      fault_code <= '0;
    end else begin
      mem_req    <= valid && !any_err;
      mem_write  <= valid && !any_err && write;
      mem_addr   <= (valid && !any_err) ? phys : '0;
      fault      <= valid && any_err;
      fault_code[FC_RANGE] <= valid && range_err;
      fault_code[FC_WRAP]  <= valid && wrap_err;
    end
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int unsigned DISP_W = 12,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_region,
  input  logic [DISP_W-1:0] acc_disp,
  input  logic              ld_en,
  input  logic              ld_region,
  input  logic              ld_field,
  input  logic [ADDR_W-1:0] ld_value,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fault,
  output logic [1:0]        fault_code
);
  logic [ADDR_W-1:0] cur_base;
  logic [ADDR_W-1:0] cur_limit;
  logic [ADDR_W-1:0] phys;
  logic              range_err;
  logic              wrap_err;

  reloc_bank #(.ADDR_W(ADDR_W), .NSETS(NREGIONS)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ld_en),
    .wr_set   (ld_region),
    .wr_field (ld_field),
    .wr_data  (ld_value),
    .rd_set   (acc_region),
    .rd_base  (cur_base),
    .rd_limit (cur_limit)
  );

  reloc_xlate #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_xlate (
    .disp      (acc_disp),
    .base      (cur_base),
    .limit     (cur_limit),
    .phys      (phys),
    .range_err (range_err),
    .wrap_err  (wrap_err)
  );

  reloc_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .valid      (acc_valid),
    .write      (acc_write),
    .phys       (phys),
    .range_err  (range_err),
    .wrap_err   (wrap_err),
    .mem_req    (mem_req),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .fault      (fault),
    .fault_code (fault_code)
  );
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int unsigned DISP_W = 12,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [DISP_W-1:0] acc_disp,
  input logic [ADDR_W-1:0] cur_base,
  input logic [ADDR_W-1:0] cur_limit,
  input logic              mem_req,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fault,
  input logic [1:0]        fault_code
);
  logic              prev_valid;
  logic [ADDR_W-1:0] prev_disp;
  logic [ADDR_W-1:0] prev_base;
  logic [ADDR_W-1:0] prev_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_disp  <= '0;
      prev_base  <= '0;
      prev_limit <= '0;
    end else begin
      prev_valid <= acc_valid;
      prev_disp  <= ADDR_W'(acc_disp);
      prev_base  <= cur_base;
      prev_limit <= cur_limit;
    end
  end

  // R2: forwarded address is the previous cycle's base plus displacement
  assert_addr_sum_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr == prev_base + prev_disp));

  // R5: nothing is forwarded whose displacement reached the limit
  assert_in_bounds_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (prev_disp < prev_limit));

  // R6: a forwarded address never wrapped past the top
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr >= prev_base));

  // R7: request and fault never together
  assert_req_fault_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && fault));

  // R7: any output activity is caused by an access one cycle earlier
  assert_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req || fault) |-> prev_valid);

  // R7: a fault always carries at least one reason bit
  assert_fault_reason_R7: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($countones(fault_code) != 0));

  // R10: idle output is quiet
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_req |-> (mem_addr == '0 && !mem_write));
endmodule

bind reloc_guard reloc_guard_chk #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_disp   (acc_disp),
  .cur_base   (cur_base),
  .cur_limit  (cur_limit),
  .mem_req    (mem_req),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .fault      (fault),
  .fault_code (fault_code)
);

// File: tb/sim_reloc_guard.sv
`timescale 1ns/1ps
module sim_reloc_guard;
  localparam int DISP_W = 12;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              acc_valid, acc_write, acc_region;
  logic [DISP_W-1:0] acc_disp;
  logic              ld_en, ld_region, ld_field;
  logic [ADDR_W-1:0] ld_value;
  logic              mem_req, mem_write, fault;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0]        fault_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk; // 125 MHz

  reloc_guard #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_region(acc_region), .acc_disp(acc_disp), .ld_en(ld_en),
    .ld_region(ld_region), .ld_field(ld_field), .ld_value(ld_value),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .fault(fault), .fault_code(fault_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic rgn, input logic fld, input logic [ADDR_W-1:0] v);
    ld_en = 1; ld_region = rgn; ld_field = fld; ld_value = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  // Issue one access, then sample the registered outputs one cycle later
  task automatic access(input logic rgn, input logic wr, input logic [DISP_W-1:0] d);
    acc_valid = 1; acc_region = rgn; acc_write = wr; acc_disp = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic expect_ok(input string req, input logic [ADDR_W-1:0] a, input logic wr);
    check({req, " req"}, mem_req, 1);
    check({req, " addr"}, mem_addr, a);
    check({req, " wr"}, mem_write, wr);
    check({req, " fault"}, fault, 0);
  endtask

  task automatic expect_fault(input string req, input logic [1:0] code);
    check({req, " fault"}, fault, 1);
    check({req, " code"}, fault_code, code);
    check({req, " req"}, mem_req, 0);
  endtask

  task automatic t_reset_R1;
    check("R1 req", mem_req, 0);
    check("R1 fault", fault, 0);
    access(0, 0, 0);
    expect_fault("R1 private limit zero", 2'b01);
    access(1, 0, 0);
    expect_fault("R1 shared limit zero", 2'b01);
  endtask

  task automatic t_translate_R2_R3;
    load(0, 0, 16'd100); load(0, 1, 16'd200);
    load(1, 0, 16'd1000); load(1, 1, 16'd16);
    access(0, 1, 12'd7);  expect_ok("R2 write", 16'd107, 1);
    access(0, 0, 12'd0);  expect_ok("R2 read", 16'd100, 0);
    access(1, 0, 12'd3);  expect_ok("R3 shared", 16'd1003, 0);
  endtask

  task automatic t_limit_R5;
    access(1, 0, 12'd15);  expect_ok("R5 shared last", 16'd1015, 0);
    access(1, 0, 12'd16);  expect_fault("R5 shared at limit", 2'b01);
    access(0, 1, 12'd199); expect_ok("R5 private last", 16'd299, 1);
    access(0, 1, 12'd200); expect_fault("R5 private at limit", 2'b01);
  endtask

  task automatic t_idle_R7_R10;
    access(0, 0, 12'd300);
    expect_fault("R7 fault", 2'b01);
    @(negedge clk);
    check("R7 pulse ends", fault, 0);
    check("R7 no req", mem_req, 0);
    check("R10 addr zero", mem_addr, 0);
    check("R10 wr low", mem_write, 0);
  endtask

  task automatic t_relocate_R4_R9;
    load(0, 0, 16'd500);
    access(0, 0, 12'd7);   expect_ok("R4 moved", 16'd507, 0);
    access(0, 0, 12'd200); expect_fault("R4 limit kept", 2'b01);
    access(1, 0, 12'd3);   expect_ok("R9 shared untouched", 16'd1003, 0);
  endtask

  task automatic t_same_cycle_R8;
    // load and access in the same cycle: old base 500 applies
    ld_en = 1; ld_region = 0; ld_field = 0; ld_value = 16'd900;
    acc_valid = 1; acc_region = 0; acc_write = 0; acc_disp = 12'd5;
    @(negedge clk);
    ld_en = 0; acc_valid = 0;
    expect_ok("R8 old base", 16'd505, 0);
    access(0, 0, 12'd5);
    expect_ok("R8 new base", 16'd905, 0);
  endtask

  task automatic t_wrap_R6;
    load(1, 0, 16'hFFF0); load(1, 1, 16'd4095);
    access(1, 1, 12'd15); expect_ok("R6 top address", 16'hFFFF, 1);
    access(1, 1, 12'd16); expect_fault("R6 wrap", 2'b10);
    load(1, 1, 16'd10);
    access(1, 0, 12'd20); expect_fault("R7 both reasons", 2'b11);
    access(0, 0, 12'd5);  expect_ok("R9 private untouched", 16'd905, 0);
  endtask

  initial begin
    rst = 1; acc_valid = 0; acc_write = 0; acc_region = 0; acc_disp = '0;
    ld_en = 0; ld_region = 0; ld_field = 0; ld_value = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_R1;
    t_translate_R2_R3;
    t_limit_R5;
    t_idle_R7_R10;
    t_relocate_R4_R9;
    t_same_cycle_R8;
    t_wrap_R6;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule